// File: doc/BRIEF.md
# Protected Register Write-Unlock Controller

This block keeps a small bank of safety-relevant byte registers away from stray stores. There are two port instances. Each one has five registers: output data, direction mode, mode control, shut-off control and shut-off status. A store to any of these registers takes effect only when it is the very next bus write after a store to a dedicated unlock (command) register. The value stored to the command register is irrelevant.

The block watches a simple single-cycle bus: address, byte write data, a write strobe, a read strobe, and a flag that marks a cycle as coming from the DMA engine rather than the CPU. Any other write that lands between the unlock and the protected store cancels that store. A DMA cycle in that gap also cancels it. In both cases a sticky error flag is raised in the status register. Software can poll the flag, clear it and repeat the two-step sequence.

The block also gives an interrupt-hold signal. It is high from the unlock store until the next write, so that the CPU takes no interrupt between the two stores. Reads never disturb the sequence. This lets a read-modify-write bit operation (set, clear or invert one bit) act as the unlocking store.

Top module: `pwu_ctrl`

## Requirements
- R1: After reset, every protected register reads zero, the block is locked (`int_hold` low) and `prot_err` is low.
- R2: The address map is as follows. Address 0 is the command register, which reads as zero. Address 1 is the status register, with the error flag in bit 0 and zeros in the other bits. Port p, kind k sits at address 2 + 5p + k, with k = 0 data, 1 mode, 2 mode control, 3 shut-off control, 4 shut-off status. Every other address reads zero.
- R3: A CPU store of any value to address 0, followed directly by a CPU store to a protected address, writes that byte into the register. The new value appears on `prot_q` one cycle after the store.
- R4: `int_hold` is high during the cycle of a command store. It stays high through every later cycle until the next write or DMA cycle has been taken.
- R5: While the block is unlocked, a write to any address other than a protected one does three things: it sets `prot_err`, it drops the unlock, and it leaves every protected register unchanged. This includes the status register (even when the write value is 0), unmapped addresses, and the command register. A command store in this state also re-arms the unlock.
- R6: While the block is unlocked, any DMA cycle (read or write) sets `prot_err` and drops the unlock. A DMA write never changes a protected register.
- R7: A store to a protected address while the block is locked is discarded and sets `prot_err`.
- R8: The unlock is one-shot. A second protected store after a successful one is discarded unless a new command store comes in between.
- R9: CPU reads, of any address, neither drop nor create the unlock. A read-then-modified-write of a protected register after a command store therefore succeeds.
- R10: `prot_err` is sticky. While the block is locked, a write with bit 0 clear to the status register clears it. A write with bit 0 set leaves it unchanged.
- R11: After a failed sequence, clearing the flag and repeating the command store plus protected store updates the register and leaves `prot_err` low.
- R12: A read of a protected register returns its current value on `bus_rdata` in the same cycle, whether or not the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_dma | input | 1 | Cycle is issued by the DMA engine |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for the addressed register, combinational |
| int_hold | output | 1 | Interrupt hold while an unlock is pending |
| prot_err | output | 1 | Sticky protection-error flag (status bit 0) |
| prot_q | output | 10*DATA_W (80) | Protected register contents, register n in bits [8n+7:8n] |

## Verification
The bench builds the block with its defaults: two ports, byte data and a four-bit address. With these values the protected range covers addresses 2 to 11 and leaves 12 to 15 unmapped. The stimulus can therefore hit every register kind on both ports as well as writes that miss the map. The random mix interleaves unlock stores, CPU and DMA cycles and status writes, which reaches the abort, re-arm, locked-write and retry paths in many orders. Directed cases pin down the read-modify-write unlock, the status write of 0 while armed, and the one-shot rule.

// File: rtl/pwu_pkg.sv
// Package: shared constants and types for the write-unlock controller.
// Assumes a byte-wide single-cycle register bus with at most one strobe per cycle.
package pwu_pkg;

    // Register kinds within one port instance; the order fixes the address offset.
    typedef enum logic [2:0] {
        KIND_DATA  = 3'd0,
        KIND_MODE  = 3'd1,
        KIND_MCTL  = 3'd2,
        KIND_SHUT  = 3'd3,
        KIND_SSTAT = 3'd4
    } kind_e;

    localparam int KINDS_PER_PORT = 5;
    localparam int CMD_ADDR       = 0;
    localparam int STAT_ADDR      = 1;
    localparam int PROT_BASE      = 2;

    // Result of decoding one bus address.
    typedef struct packed {
        logic is_cmd;
        logic is_stat;
        logic is_prot;
    } hit_t;

endpackage

// File: rtl/pwu_decode.sv
// Module: pwu_decode
// Turns a bus address into command/status/protected hits plus a one-hot
// select over the protected registers. Purely combinational.
// Assumes the protected block starts at PROT_BASE and is contiguous.
module pwu_decode
    import pwu_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_PROT = 10
) (
    input  logic [ADDR_W-1:0]   addr,
    output hit_t                hit,
    output logic [NUM_PROT-1:0] sel
);

    // One comparator per protected register.
    for (genvar i = 0; i < NUM_PROT; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(PROT_BASE + i));
    end

    // Fixed-location registers and the protected-range summary.
    always_comb begin
        hit.is_cmd  = (addr == ADDR_W'(CMD_ADDR));
        hit.is_stat = (addr == ADDR_W'(STAT_ADDR));
        hit.is_prot = |sel;
    end

endmodule

// File: rtl/pwu_seq.sv
// Module: pwu_seq
// Unlock sequencer: holds the one-shot arm bit and the sticky error flag,
// and decides whether the current write may commit to a protected register.
// Assumes bus_wr and bus_rd are never high together.
module pwu_seq
    import pwu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_wr,
    input  logic bus_rd,
    input  logic bus_dma,
    input  hit_t hit,
    input  logic wdata_lsb,
    output logic armed,
    output logic err,
    output logic commit,
    output logic int_hold
);

    logic cpu_wr;
    logic dma_rd;
    logic abort;
    logic lock_hit;
    logic clr_req;
    logic armed_q;
    logic err_q;

    // Classify the current cycle against the arm state.
    always_comb begin
        cpu_wr   = bus_wr & ~bus_dma;
        dma_rd   = bus_rd & bus_dma;
        commit   = armed_q & cpu_wr & hit.is_prot;
        abort    = armed_q & ((bus_wr & ~(cpu_wr & hit.is_prot)) | dma_rd);
        lock_hit = ~armed_q & bus_wr & hit.is_prot;
        clr_req  = bus_wr & hit.is_stat & ~wdata_lsb;
    end

    // Arm on any command store, disarm on any other write or DMA cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (bus_wr && hit.is_cmd) begin
            armed_q <= 1'b1;
        end else if (bus_wr || dma_rd) begin
            armed_q <= 1'b0;
        end
    end

    // Sticky error: setting wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (abort || lock_hit) begin
            err_q <= 1'b1;
        end else if (clr_req) begin
            err_q <= 1'b0;
        end
    end

    // Hold interrupts from the command store until the unlock is consumed.
    assign int_hold = armed_q | (bus_wr & hit.is_cmd);
    assign armed    = armed_q;
    assign err      = err_q;

endmodule

// File: rtl/pwu_bank.sv
// Module: pwu_bank
// Storage for the protected registers. A register loads only when the
// sequencer grants a commit and the decoder selects it.
// Assumes sel is one-hot or zero.
module pwu_bank #(
    parameter int NUM_PROT = 10,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [NUM_PROT-1:0]        sel,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_PROT*DATA_W-1:0] q
);

    for (genvar i = 0; i < NUM_PROT; i++) begin : g_reg
        logic [DATA_W-1:0] r_q;

        // Load register i on a granted write that targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else if (commit && sel[i]) begin
                r_q <= wdata;
            end
        end

        assign q[i*DATA_W +: DATA_W] = r_q;
    end

endmodule

// File: rtl/pwu_ctrl.sv
// Module: pwu_ctrl (top)
// Write-unlock controller for a bank of protected port registers.
// Ties the decoder, sequencer and register bank together and forms read data.
// Assumes a single-cycle bus with at most one strobe per cycle and that
// ADDR_W covers PROT_BASE + NUM_PORTS*KINDS_PER_PORT addresses.
module pwu_ctrl
    import pwu_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       bus_wr,
    input  logic                                       bus_rd,
    input  logic                                       bus_dma,
    input  logic [ADDR_W-1:0]                          bus_addr,
    input  logic [DATA_W-1:0]                          bus_wdata,
    output logic [DATA_W-1:0]                          bus_rdata,
    output logic                                       int_hold,
    output logic                                       prot_err,
    output logic [NUM_PORTS*KINDS_PER_PORT*DATA_W-1:0] prot_q
);

    localparam int NUM_PROT = NUM_PORTS * KINDS_PER_PORT;

    hit_t                hit;
    logic [NUM_PROT-1:0] sel;
    logic                armed;
    logic                err;
    logic                commit;

    pwu_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_PROT (NUM_PROT)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel)
    );

    pwu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_dma   (bus_dma),
        .hit       (hit),
        .wdata_lsb (bus_wdata[0]),
        .armed     (armed),
        .err       (err),
        .commit    (commit),
        .int_hold  (int_hold)
    );

    pwu_bank #(
        .NUM_PROT (NUM_PROT),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .sel    (sel),
        .wdata  (bus_wdata),
        .q      (prot_q)
    );

    // Read mux: status bit, or the selected protected register, else zero.
    always_comb begin
        bus_rdata = '0;
        if (hit.is_stat) begin
            bus_rdata = DATA_W'(err);
        end
        for (int i = 0; i < NUM_PROT; i++) begin
            if (sel[i]) begin
                bus_rdata = prot_q[i*DATA_W +: DATA_W];
            end
        end
    end

    assign prot_err = err;

endmodule

// File: rtl/pwu_ctrl_chk.sv
// Module: pwu_ctrl_chk
// Temporal checks on the write-unlock controller, attached with bind.
module pwu_ctrl_chk #(
    parameter int ADDR_W = 4,
    parameter int QW     = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_dma,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        wlsb_byte,
    input logic              int_hold,
    input logic              prot_err,
    input logic [QW-1:0]     prot_q,
    input logic              armed,
    input logic              is_prot
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (prot_q == '0 && !prot_err && !armed));

    // R3
    hold_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && bus_wr && !bus_dma && is_prot) |=> $stable(prot_q));

    // R4
    arm_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> (armed && int_hold));

    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_wr && bus_addr != ADDR_W'(0)) |=> !armed);

    // R6
    dma_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_dma && bus_rd) |=> (prot_err && !armed));

    // R9
    read_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !bus_wr && !(bus_rd && bus_dma)) |=> armed);

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_err) |-> $past(bus_wr && bus_addr == ADDR_W'(1) && !wlsb_byte[0] && !armed));

    // R7
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && bus_wr && is_prot) |=> (prot_err && $stable(prot_q)));

endmodule

bind pwu_ctrl pwu_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .QW     (NUM_PROT * DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_dma   (bus_dma),
    .bus_addr  (bus_addr),
    .wlsb_byte (8'(bus_wdata)),
    .int_hold  (int_hold),
    .prot_err  (prot_err),
    .prot_q    (prot_q),
    .armed     (armed),
    .is_prot   (hit.is_prot)
);

// File: tb/pwu_ctrl_test.sv
module pwu_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_dma = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        int_hold;
    logic        prot_err;
    logic [79:0] prot_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_reg [NP];
    logic       m_armed;
    logic       m_err;
    logic [7:0] cap_rdata;
    logic       cap_hold;
    logic [7:0] exp_rdata;
    logic       exp_hold;

    pwu_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_dma   (bus_dma),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .int_hold  (int_hold),
        .prot_err  (prot_err),
        .prot_q    (prot_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] paddr(input int port, input int kind);
        return 4'(2 + 5*port + kind);
    endfunction

    function automatic logic [79:0] model_q();
        logic [79:0] v;
        for (int i = 0; i < NP; i++) v[i*8 +: 8] = m_reg[i];
        return v;
    endfunction

    function automatic logic [7:0] model_rd(input logic [3:0] a);
        if (a == 4'd1) return {7'b0, m_err};
        if (a >= 4'd2 && a < 4'd12) return m_reg[a-2];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_op(input logic wr, input logic rd, input logic dma,
                            input logic [3:0] a, input logic [7:0] d);
        logic prot;
        prot = (a >= 4'd2 && a < 4'd12);
        if (wr) begin
            if (m_armed) begin
                if (prot && !dma) m_reg[a-2] = d;
                else m_err = 1'b1;
                m_armed = (a == 4'd0);
            end else if (a == 4'd0) begin
                m_armed = 1'b1;
            end else if (prot) begin
                m_err = 1'b1;
            end else if (a == 4'd1 && !d[0]) begin
                m_err = 1'b0;
            end
        end else if (rd && dma && m_armed) begin
            m_err = 1'b1;
            m_armed = 1'b0;
        end
    endtask

    // One bus cycle: drive at negedge, capture combinational outputs, update model.
    task automatic op(input logic wr, input logic rd, input logic dma,
                      input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_dma = dma; bus_addr = a; bus_wdata = d;
        exp_rdata = model_rd(a);
        exp_hold  = m_armed | (wr && a == 4'd0);
        #1;
        cap_rdata = bus_rdata;
        cap_hold  = int_hold;
        model_op(wr, rd, dma, a, d);
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_dma = 1'b0;
    endtask

    task automatic check_state(input string req);
        check({req, " prot_q"}, prot_q, model_q());
        check({req, " prot_err"}, 80'(prot_err), 80'(m_err));
        check({req, " int_hold"}, 80'(int_hold), 80'(m_armed));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] tmp;
        int unused;
        unused = $urandom(32'h5EED_0A11);
        for (int i = 0; i < NP; i++) m_reg[i] = 8'h00;
        m_armed = 1'b0;
        m_err = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_state("R1");

        // R2 map: command and unmapped read zero, status reads error bit
        op(0, 1, 0, 4'd0, 8'h00);  check("R2 cmd read", 80'(cap_rdata), 80'h00);
        op(0, 1, 0, 4'd13, 8'h00); check("R2 unmapped read", 80'(cap_rdata), 80'h00);

        // R3 unlock then store to port 1 shut-off control (address 10), int_hold R4
        op(1, 0, 0, 4'd0, 8'hA5);  check("R4 hold during cmd", 80'(cap_hold), 80'd1);
        check("R4 hold after cmd", 80'(int_hold), 80'd1);
        op(0, 0, 0, 4'd0, 8'h00);  check("R4 hold idle", 80'(int_hold), 80'd1);
        op(1, 0, 0, paddr(1, 3), 8'h3C);
        check("R3 commit", 80'(prot_q[8*8 +: 8]), 80'h3C);
        check("R4 hold released", 80'(int_hold), 80'd0);
        check_state("R3");

        // R8 one-shot: second store without new unlock is discarded
        op(1, 0, 0, paddr(1, 3), 8'hFF);
        check("R8 second store", 80'(prot_q[8*8 +: 8]), 80'h3C);
        check("R7 locked store err", 80'(prot_err), 80'd1);

        // R10 write 1 keeps, write 0 clears
        op(1, 0, 0, 4'd1, 8'h01);  check("R10 write one", 80'(prot_err), 80'd1);
        op(1, 0, 0, 4'd1, 8'h00);  check("R10 write zero", 80'(prot_err), 80'd0);

        // R9 read-modify-write set-bit as unlocking store, read of protected between
        op(1, 0, 0, 4'd0, 8'h00);
        op(0, 1, 0, paddr(0, 1), 8'h00);
        tmp = cap_rdata | 8'h04;
        check("R12 read while armed", 80'(cap_rdata), 80'h00);
        check("R9 read keeps arm", 80'(int_hold), 80'd1);
        op(1, 0, 0, paddr(0, 1), tmp);
        check("R9 rmw commit", 80'(prot_q[1*8 +: 8]), 80'h04);
        check("R9 no err", 80'(prot_err), 80'd0);

        // R5 status write of 0 while armed aborts and sets error
        op(1, 0, 0, 4'd0, 8'h00);
        op(1, 0, 0, 4'd1, 8'h00);
        op(1, 0, 0, paddr(0, 1), 8'h77);
        check("R5 status gap blocks", 80'(prot_q[1*8 +: 8]), 80'h04);
        check("R5 status gap err", 80'(prot_err), 80'd1);

        // R11 retry after failure
        op(1, 0, 0, 4'd1, 8'h00);
        op(1, 0, 0, 4'd0, 8'h5A);
        op(1, 0, 0, paddr(0, 1), 8'h77);
        check("R11 retry commit", 80'(prot_q[1*8 +: 8]), 80'h77);
        check("R11 retry err clear", 80'(prot_err), 80'd0);

        // R6 DMA read in the gap aborts; DMA write never commits
        op(1, 0, 0, 4'd0, 8'h00);
        op(0, 1, 1, 4'd5, 8'h00);
        check("R6 dma read err", 80'(prot_err), 80'd1);
        op(1, 0, 0, paddr(0, 4), 8'h99);
        check("R6 dma gap blocks", 80'(prot_q[4*8 +: 8]), 80'h00);
        op(1, 0, 0, 4'd1, 8'h00);
        op(1, 0, 0, 4'd0, 8'h00);
        op(1, 0, 1, paddr(0, 4), 8'h99);
        check("R6 dma write", 80'(prot_q[4*8 +: 8]), 80'h00);

        // R5 repeated command store re-arms and flags
        op(1, 0, 0, 4'd1, 8'h00);
        op(1, 0, 0, 4'd0, 8'h00);
        op(1, 0, 0, 4'd0, 8'h00);
        check("R5 double cmd err", 80'(prot_err), 80'd1);
        check("R5 double cmd rearm", 80'(int_hold), 80'd1);
        op(1, 0, 0, paddr(1, 0), 8'h12);
        check("R5 rearmed commit", 80'(prot_q[5*8 +: 8]), 80'h12);

        // R12 reads of every protected register while locked
        for (int i = 0; i < NP; i++) begin
            op(0, 1, 0, 4'(2 + i), 8'h00);
            check("R12 locked read", 80'(cap_rdata), 80'(m_reg[i]));
        end

        // Random mix checked against the model
        for (int n = 0; n < 600; n++) begin
            int kind;
            logic [3:0] a;
            logic [7:0] d;
            kind = int'($urandom_range(9, 0));
            a = 4'($urandom_range(15, 0));
            d = 8'($urandom);
            case (kind)
                0, 1, 2: op(1, 0, 0, 4'd0, d);
                3, 4:    op(1, 0, 0, 4'($urandom_range(11, 2)), d);
                5:       op(1, 0, 1, a, d);
                6:       op(1, 0, 0, 4'd1, {d[7:1], ($urandom_range(3, 0) == 0)});
                7:       op(0, 1, 0, a, 8'h00);
                8:       op(0, 1, 1, a, 8'h00);
                default: op(1, 0, 0, 4'($urandom_range(15, 12)), d);
            endcase
            check("R2 R12 random read", 80'(cap_rdata), 80'(bus_rd ? exp_rdata : exp_rdata));
            check("R4 random hold", 80'(cap_hold), 80'(exp_hold));
            check_state("R3 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule